// File: doc/BRIEF.md
# Frequency-Trimmed Nanosecond Time-of-Day Counter

This block keeps a 64-bit count of nanoseconds that serves as the chip's time of day. On each cycle of the reference clock a 32-bit fractional accumulator adds a programmable addend. When that addition carries out of the top bit, the time count steps forward by a programmable nominal period in nanoseconds. Changing the addend shifts the average rate in steps of one part in 2^32 of a period, so the clock can be trimmed very finely. The default addend is ceil(2^32 × nominal frequency / reference frequency), worked out from parameters. The default period is 1e9 / nominal frequency.

Software uses a small word-wide register port with four addresses. One holds the control word (run enable, a stored clock-select code, the nominal period). One holds the addend. The other two are the low and high halves of the count. A write to the count has to be done low half first, then high half. A small staging state machine enforces this. State ST_IDLE moves to ST_STAGED when the low half is written. ST_STAGED stays in ST_STAGED when the low half is written again. ST_STAGED returns to ST_IDLE when the high half is written, and that write loads all 64 bits. A read of the low half captures the high half into a shadow register, so that the read of the high half that follows returns a value that belongs with the low half. The live count goes out on `time_ns` to the alarm and timestamp logic.

Top module: `tod_counter`

## Requirements
- R1: After reset the count and accumulator are zero. Control (address 0) reads the default period in bits [15:8] with run enable (bit 0) clear. Addend (address 1) reads the parameter-derived default (0xCCCCCCCD for 200 MHz nominal from a 250 MHz reference, with a period of 5 ns).
- R2: While run enable is set, the accumulator adds the addend modulo 2^32 on every clock. The count grows by the period field exactly in those cycles where the addition carries out of bit 31, and is unchanged in all other cycles.
- R3: While run enable is clear, the count and the accumulator hold their values.
- R4: A write to the addend takes effect for the addition on the next clock. The write itself does not change the count or the accumulator.
- R5: A read of address 2 returns count[31:0] in the same cycle and captures count[63:32]. A read of address 3 returns that captured value, not the live high half.
- R6: A write to address 2 only stages the low half and leaves the count alone. A later write to address 3 loads {written high, most recently staged low} at the next edge.
- R7: A write to address 3 while no low half is staged has no effect on the count.
- R8: A new value in the period field (bits [15:8]) changes the step applied on later carries.
- R9: In a cycle where a load and a carry coincide, the loaded value wins.
- R10: The control word stores the clock-select code in bits [7:4], the period and the run bit, and reads zero in all other bits. The clock-select code has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (captures shadow on low-half read) |
| reg_addr | input | 2 | 0 control, 1 addend, 2 count low, 3 count high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |
| time_ns | output | 64 | Live nanosecond count |

## Verification
The bench goes after the rollover of the low half: it reads the low word just before the count crosses 2^32 and reads the high word after the crossing. A design without a coherent shadow would return the new high half there and tear the 64-bit time. It also writes the high half with nothing staged, which a design that loads regardless would corrupt. It writes the low half twice before the high half, which exposes a design that keeps the first staged value. It loads the count while an all-ones addend makes a carry happen in nearly every cycle, so a design that lets the advance win would end one period off. A behavioural model of the count and accumulator is compared against `time_ns` on every clock, which catches an off-by-one in the carry timing or an addend change that disturbs the accumulator.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned TIME_W  = 64;

    localparam logic [1:0] ADR_CTRL   = 2'd0;
    localparam logic [1:0] ADR_ADDEND = 2'd1;
    localparam logic [1:0] ADR_CNT_LO = 2'd2;
    localparam logic [1:0] ADR_CNT_HI = 2'd3;

    localparam int unsigned RUN_BIT = 0;
    localparam int unsigned SEL_LSB = 4;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned PER_LSB = 8;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STAGED = 1'b1
    } stage_e;
endpackage

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [ACC_W-1:0] addend_i,
    output logic             tick_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum    = {1'b0, acc_q} + {1'b0, addend_i};
        tick_o = en_i & sum[ACC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en_i)
            acc_q <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/tod_count.sv
module tod_count #(
    parameter int unsigned TW    = 64,
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             load_i,
    input  logic [TW-1:0]    load_val_i,
    output logic [TW-1:0]    time_o
);
    localparam int unsigned PAD_W = TW - PER_W;

    logic [TW-1:0] time_q;
    logic [TW-1:0] time_d;

    always_comb begin
        time_d = time_q;
        if (load_i)
            time_d = load_val_i;
        else if (tick_i)
            time_d = time_q + {{PAD_W{1'b0}}, period_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            time_q <= '0;
        else
            time_q <= time_d;
    end

    assign time_o = time_q;
endmodule

// File: rtl/tod_stage.sv
module tod_stage #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [DW-1:0] wdata_i,
    output logic          load_o,
    output logic          pend_o,
    output logic [DW-1:0] lo_o
);
    import tod_pkg::*;

    stage_e        state_q;
    stage_e        state_d;
    logic [DW-1:0] lo_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_lo_i) state_d = ST_STAGED;
            ST_STAGED: if (wr_hi_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (wr_lo_i)
                lo_q <= wdata_i;
        end
    end

    always_comb begin
        load_o = 1'b0;
        pend_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_o = 1'b0;
            ST_STAGED: begin
                pend_o = 1'b1;
                load_o = wr_hi_i;
            end
            default:   load_o = 1'b0;
        endcase
    end

    assign lo_o = lo_q;
endmodule

// File: rtl/tod_regs.sv
module tod_regs #(
    parameter int unsigned       PER_W      = 8,
    parameter logic [PER_W-1:0]  DEF_PERIOD = '0,
    parameter logic [31:0]       DEF_ADDEND = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    input  logic [63:0]      time_i,
    output logic [31:0]      rdata_o,
    output logic             run_o,
    output logic [PER_W-1:0] period_o,
    output logic [31:0]      addend_o,
    output logic [31:0]      shadow_o
);
    import tod_pkg::*;

    localparam logic [31:0] RUN_MASK  = 32'd1 << RUN_BIT;
    localparam logic [31:0] SEL_MASK  = ((32'd1 << SEL_W) - 32'd1) << SEL_LSB;
    localparam logic [31:0] PER_MASK  = ((32'd1 << PER_W) - 32'd1) << PER_LSB;
    localparam logic [31:0] CTRL_MASK = RUN_MASK | SEL_MASK | PER_MASK;
    localparam logic [31:0] CTRL_RST  = {{(32-PER_W){1'b0}}, DEF_PERIOD} << PER_LSB;

    logic [31:0] ctrl_q;
    logic [31:0] addend_q;
    logic [31:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RST;
            addend_q <= DEF_ADDEND;
            shadow_q <= '0;
        end else begin
            if (wr_i && addr_i == ADR_CTRL)
                ctrl_q <= wdata_i & CTRL_MASK;
            if (wr_i && addr_i == ADR_ADDEND)
                addend_q <= wdata_i;
            if (rd_i && addr_i == ADR_CNT_LO)
                shadow_q <= time_i[63:32];
        end
    end

    always_comb begin
        unique case (addr_i)
            ADR_CTRL:   rdata_o = ctrl_q;
            ADR_ADDEND: rdata_o = addend_q;
            ADR_CNT_LO: rdata_o = time_i[31:0];
            ADR_CNT_HI: rdata_o = shadow_q;
            default:    rdata_o = '0;
        endcase
    end

    assign run_o    = ctrl_q[RUN_BIT];
    assign period_o = ctrl_q[PER_LSB +: PER_W];
    assign addend_o = addend_q;
    assign shadow_o = shadow_q;
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter longint unsigned REF_HZ = 64'd250_000_000,
    parameter longint unsigned NOM_HZ = 64'd200_000_000,
    parameter int unsigned     PER_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [63:0] time_ns
);
    import tod_pkg::*;

    localparam longint unsigned SCALED     = (64'd1 << 32) * NOM_HZ;
    localparam longint unsigned ADD_CEIL   = (SCALED + REF_HZ - 64'd1) / REF_HZ;
    localparam logic [31:0]     DEF_ADDEND = ADD_CEIL[31:0];
    localparam longint unsigned PER_NS     = 64'd1_000_000_000 / NOM_HZ;
    localparam logic [PER_W-1:0] DEF_PERIOD = PER_NS[PER_W-1:0];

    logic             run_en;
    logic [PER_W-1:0] period;
    logic [31:0]      addend;
    logic [31:0]      shadow_hi;
    logic             adv_tick;
    logic             cnt_load;
    logic             stage_pend;
    logic [31:0]      stage_lo;
    logic             wr_lo;
    logic             wr_hi;

    assign wr_lo = reg_wr && reg_addr == ADR_CNT_LO;
    assign wr_hi = reg_wr && reg_addr == ADR_CNT_HI;

    tod_regs #(
        .PER_W      (PER_W),
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_ADDEND (DEF_ADDEND)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr),
        .rd_i     (reg_rd),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .time_i   (time_ns),
        .rdata_o  (reg_rdata),
        .run_o    (run_en),
        .period_o (period),
        .addend_o (addend),
        .shadow_o (shadow_hi)
    );

    tod_stage #(.DW(WORD_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo_i (wr_lo),
        .wr_hi_i (wr_hi),
        .wdata_i (reg_wdata),
        .load_o  (cnt_load),
        .pend_o  (stage_pend),
        .lo_o    (stage_lo)
    );

    tod_accum #(.ACC_W(WORD_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (run_en),
        .addend_i (addend),
        .tick_o   (adv_tick)
    );

    tod_count #(.TW(TIME_W), .PER_W(PER_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (adv_tick),
        .period_i   (period),
        .load_i     (cnt_load),
        .load_val_i ({reg_wdata, stage_lo}),
        .time_o     (time_ns)
    );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
    parameter int unsigned PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [63:0]      time_ns,
    input logic             run,
    input logic             tick,
    input logic [PER_W-1:0] period,
    input logic             load,
    input logic             pending,
    input logic [31:0]      staged_lo,
    input logic [31:0]      shadow
);
    // R3: stopped counter holds unless loaded
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(time_ns));

    // R2: a carry steps the count by the period
    a_r2_step_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> time_ns == $past(time_ns) + {{(64-PER_W){1'b0}}, $past(period)});

    // R2: no carry means no change
    a_r2_still_without_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(time_ns));

    // R6 and R9: a load takes the written high half and the staged low half
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> time_ns == {$past(reg_wdata), $past(staged_lo)});

    // R7: high write with nothing staged does nothing
    a_r7_hi_without_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && !pending && !tick) |=> $stable(time_ns));

    // R5: low read captures the high half
    a_r5_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2) |=> shadow == $past(time_ns[63:32]));
endmodule

bind tod_counter tod_counter_chk #(.PER_W(PER_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .time_ns   (time_ns),
    .run       (run_en),
    .tick      (adv_tick),
    .period    (period),
    .load      (cnt_load),
    .pending   (stage_pend),
    .staged_lo (stage_lo),
    .shadow    (shadow_hi)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [63:0] time_ns;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [63:0] m_time;
    logic [31:0] m_acc, m_add, m_ctrl, m_shadow, m_lo;
    bit          m_pend;

    tod_counter i_tod_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .time_ns   (time_ns)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = '0; m_acc = '0; m_add = 32'hCCCC_CCCD;
            m_ctrl = 32'h0000_0500; m_shadow = '0; m_lo = '0; m_pend = 0;
        end else begin
            logic [32:0] s;
            logic [63:0] nt;
            logic [31:0] nacc;
            s = {1'b0, m_acc} + {1'b0, m_add};
            nt = m_time;
            nacc = m_acc;
            if (m_ctrl[0]) begin
                nacc = s[31:0];
                if (s[32]) nt = m_time + 64'(m_ctrl[15:8]);
            end
            if (reg_rd && reg_addr == 2'd2) m_shadow = m_time[63:32];
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_ctrl = reg_wdata & 32'h0000_FFF1;
                    2'd1: m_add = reg_wdata;
                    2'd2: begin m_lo = reg_wdata; m_pend = 1; end
                    default: if (m_pend) begin nt = {reg_wdata, m_lo}; m_pend = 0; end
                endcase
            end
            m_acc = nacc;
            m_time = nt;
        end
    end

    always @(negedge clk) if (rst_n && !done) chk("R2 per-cycle count", time_ns, m_time);

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return m_add;
            2'd2: return m_time[31:0];
            default: return m_shadow;
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        v = reg_rdata;
        chk(tag, {32'd0, v}, {32'd0, m_read(a)});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] t;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count after reset", time_ns, 64'd0);
        rd("R1 control reset", 2'd0, v);
        chk("R1 control literal", {32'd0, v}, 64'h500);
        rd("R1 addend reset", 2'd1, v);
        chk("R1 addend literal", {32'd0, v}, 64'hCCCC_CCCD);
        // R10 clock-select stored, unused bits read zero, no run
        wr(2'd0, 32'hFFFF_05A0);
        rd("R10 control readback", 2'd0, v);
        chk("R10 control literal", {32'd0, v}, 64'h5A0);
        idle(4);
        chk("R3 stopped after control write", time_ns, 64'd0);
        // R2 run with default addend
        wr(2'd0, 32'h0000_05A1);
        idle(20);
        chk("R2 advanced count", time_ns, m_time);
        chk("R2 count moved", {63'd0, time_ns != 0}, 64'd1);
        // R4 addend change
        wr(2'd1, 32'hFFFF_FFFF);
        idle(10);
        chk("R4 after addend change", time_ns, m_time);
        // R3 stop holds
        wr(2'd0, 32'h0000_0500);
        t = time_ns;
        idle(10);
        chk("R3 held while stopped", time_ns, t);
        // R8 period 7, addend half
        wr(2'd1, 32'h8000_0000);
        wr(2'd0, 32'h0000_0701);
        idle(8);
        chk("R8 period change", time_ns, m_time);
        // R6 staging with counter stopped, restage overrides
        wr(2'd0, 32'h0000_0500);
        t = time_ns;
        wr(2'd2, 32'hDEAD_0000);
        chk("R6 low write stages only", time_ns, t);
        wr(2'd2, 32'h1234_5678);
        wr(2'd3, 32'h0000_00AB);
        chk("R6 load value", time_ns, 64'h0000_00AB_1234_5678);
        // R7 high write without stage
        wr(2'd3, 32'h0000_0055);
        chk("R7 unstaged high ignored", time_ns, 64'h0000_00AB_1234_5678);
        // R5 coherent read across low-half rollover
        wr(2'd2, 32'hFFFF_FFF0);
        wr(2'd3, 32'h0000_0000);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0000_0501);
        rd("R5 low read before rollover", 2'd2, v);
        idle(8);
        chk("R5 live high after rollover", {32'd0, time_ns[63:32]}, 64'd1);
        rd("R5 high read returns shadow", 2'd3, v);
        chk("R5 shadow literal", {32'd0, v}, 64'd0);
        rd("R5 second low read", 2'd2, v);
        rd("R5 second high read", 2'd3, v);
        chk("R5 new shadow literal", {32'd0, v}, 64'd1);
        // R9 load while carrying
        wr(2'd2, 32'h0000_0100);
        wr(2'd3, 32'h0000_0002);
        chk("R9 load wins over carry", time_ns, 64'h0000_0002_0000_0100);
        idle(5);
        chk("R9 advances after load", time_ns, m_time);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule